// File: doc/BRIEF.md
# PR4 Maximum-Likelihood Sequence Detector

This block recovers a binary write sequence from read-back samples that an upstream equalizer has already shaped to the class-4 partial-response target (1-D)(1+D) = 1-D². With bit values a∈{0,1} and amplitude AMP, a noiseless sample is AMP·(a[k] − a[k−2]). It can therefore only take the values −AMP, 0 or +AMP. The detector accepts one signed sample per `in_valid` strobe. For every accepted sample it emits one hard-decision bit, which is delayed by a fixed number of samples.

A 1-D² channel is two independent 1-D (dicode) channels, one on even-indexed samples and one on odd-indexed samples. The block therefore runs two two-state detectors and alternates between them, switching after every accepted sample. Each detector keeps one signed difference metric instead of two path metrics. Each sample is compared against two thresholds that depend on that metric. The result decides one of three actions:
- both survivors merge onto state 0;
- both survivors merge onto state 1;
- both survivors extend unchanged.

Survivors are held in a register-exchange memory. The decided bit is read from its oldest position.

Top module: `pr4_ml_detector`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `out_bit` are 0. For the first LAT = 2·DEPTH−2 accepted samples, `out_valid` stays 0.
- R2: When sample number k (counted from 0 since reset) is accepted with k ≥ LAT, `out_valid` is 1 in the following cycle. In that cycle `out_bit` carries the decision for bit k−LAT.
- R3: Samples alternate between two independent detectors. The first sample after reset, which is even-indexed, goes to one detector, and each sample's expected value depends only on the bit two samples earlier.
- R4: For noiseless input AMP·(a[k]−a[k−2]), every emitted bit equals the sent bit, provided neither interleave repeats the same bit more than 5 times in a row.
- R5: With additive noise of magnitude at most 2 (AMP = 5, DEPTH = 16, same run limit as R4), every emitted bit equals the sent bit. The internal difference metrics stay within ±(2^SW + AMP), except for their reset value.
- R6: A cycle with `in_valid` low changes no detector state, and `out_valid` is 0 in the next cycle. The value on `in_sample` in such a cycle has no effect on later decisions.
- R7: After reset, the detector assumes that both bits written before the first sample were 0. A first sample of +AMP therefore decodes as a 1.
- R8: A reset in the middle of a stream clears the fill count and the detector state. The new stream then behaves as in R1, R2 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | SW | Signed two's-complement equalized sample |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | Hard-decision recovered bit |

## Verification
The bench drives streams whose samples sit close to the decision thresholds: ±AMP with noise of ±2, and zero-level samples pushed to ±2. A detector with a wrong threshold, or one that swaps the two merge cases, misdecodes bits that follow a transition. Patterns where one interleave toggles every sample and the other every second sample expose any mixing between the two halves. Decoding only works if each half sees its own history. Bursts of idle cycles carrying garbage samples would corrupt later bits, or produce extra strobes, in a design that does not fully ignore them. A first bit of 1 right after reset, and a reset in mid-stream, catch a wrong start state or a fill counter that does not restart. Either fault shows up as wrong early bits or a strobe one sample early or late.

// File: rtl/pr4_ml_detector.sv
module pr4_ml_detector #(
  parameter int SW    = 4,
  parameter int AMP   = 5,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  output logic                 out_valid,
  output logic                 out_bit
);
  localparam int DW  = SW + 3;
  localparam int CW  = DW + 2;
  localparam int LAT = 2 * DEPTH - 2;
  localparam int NW  = $clog2(LAT + 1);
  localparam logic signed [DW-1:0] DM_INIT = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [CW-1:0] AMPC    = CW'(AMP);

  logic              phase;
  logic [NW-1:0]     fill;
  logic [1:0]        oldest;
  logic signed [CW-1:0] zs;

  assign zs = {{(CW-SW-1){in_sample[SW-1]}}, in_sample, 1'b0};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic signed [DW-1:0] dm;
    logic signed [DW-1:0] dm_nx;
    logic signed [CW-1:0] dmx, up_val, dn_val;
    logic [DEPTH-2:0]     sv0, sv1, base0, base1;
    logic                 up, dn, take;

    assign dmx    = {{2{dm[DW-1]}}, dm};
    assign up     = zs > (AMPC - dmx);
    assign dn     = zs < (-dmx - AMPC);
    assign up_val = AMPC - zs;
    assign dn_val = -zs - AMPC;
    assign dm_nx  = up ? up_val[DW-1:0] : (dn ? dn_val[DW-1:0] : dm);
    assign base0  = dn ? sv1 : sv0;
    assign base1  = up ? sv0 : sv1;
    assign take   = in_valid && (phase == 1'(h));
    assign oldest[h] = base0[DEPTH-2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dm  <= DM_INIT;
        sv0 <= '0;
        sv1 <= '0;
      end else if (take) begin
        dm  <= dm_nx;
        sv0 <= {base0[DEPTH-3:0], 1'b0};
        sv1 <= {base1[DEPTH-3:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid && (fill == NW'(LAT));
      if (in_valid) begin
        phase   <= ~phase;
        out_bit <= oldest[phase];
        if (fill != NW'(LAT)) fill <= fill + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pr4_ml_detector_chk.sv
module pr4_ml_detector_chk #(
  parameter int SW    = 4,
  parameter int AMP   = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [SW+2:0] dm0,
  input logic [SW+2:0] dm1
);
  localparam int LAT   = 2 * DEPTH - 2;
  localparam int BND   = (1 << SW) + AMP;
  localparam int DINIT = (1 << (SW + 2)) - 1;

  int seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 0;
    else if (in_valid && seen <= LAT) seen <= seen + 1;
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seen < LAT) |=> !out_valid);

  // R2
  stream_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seen >= LAT) |=> out_valid);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(dm0) == DINIT) || ($signed(dm0) <= BND && $signed(dm0) >= -BND));

  // R5
  no_overflow_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(dm1) == DINIT) || ($signed(dm1) <= BND && $signed(dm1) >= -BND));
endmodule

bind pr4_ml_detector pr4_ml_detector_chk #(.SW(SW), .AMP(AMP), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .dm0(g_half[0].dm), .dm1(g_half[1].dm)
);

// File: tb/pr4_ml_detector_bench.sv
module pr4_ml_detector_bench;
  localparam int SW = 4, AMP = 5, DEPTH = 16, LAT = 2 * DEPTH - 2, MAXRUN = 5;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic out_valid, out_bit;

  always #5 clk = ~clk;

  pr4_ml_detector #(.SW(SW), .AMP(AMP), .DEPTH(DEPTH)) u_pr4_ml_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_bit(out_bit));

  int checks = 0, errors = 0;
  string req = "R1";
  bit exp_v = 0, exp_b = 0, h1 = 0, h2 = 0, done = 0;
  bit sent[$];
  int nsent = 0;
  int run[2];
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd(int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff) % m;
  endfunction

  task automatic chk(string r, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
    end
  endtask

  task automatic model_clear();
    sent.delete(); nsent = 0; h1 = 0; h2 = 0; run[0] = 0; run[1] = 0; exp_v = 0;
  endtask

  task automatic step(bit v, int y);
    @(negedge clk);
    chk(req, out_valid, exp_v, "out_valid");
    if (exp_v) chk(req, out_bit, exp_b, "out_bit");
    in_valid = v;
    in_sample = SW'(y);
    if (v) begin
      exp_v = (nsent >= LAT);
      if (exp_v) exp_b = sent[nsent - LAT];
    end else exp_v = 0;
  endtask

  task automatic put(bit a_in, int noise, int gap);
    bit a;
    int y;
    a = a_in;
    if (run[nsent % 2] >= MAXRUN && a == h2) a = ~h2;
    if (a == h2) run[nsent % 2]++; else run[nsent % 2] = 0;
    y = AMP * (int'(a) - int'(h2)) + noise;
    if (y > 7) y = 7;
    if (y < -8) y = -8;
    while (gap > 0 && rnd(100) < gap) step(0, rnd(16) - 8);
    step(1, y);
    sent.push_back(a);
    nsent++;
    h2 = h1;
    h1 = a;
  endtask

  task automatic rand_bits(int n, int nmax, int gap);
    repeat (n) begin
      bit a;
      int nz;
      a = bit'(rnd(2));
      nz = (nmax > 0) ? rnd(2 * nmax + 1) - nmax : 0;
      put(a, nz, gap);
    end
  endtask

  task automatic flush(int n);
    repeat (n) step(0, 0);
  endtask

  initial begin
    model_clear();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    req = "R1";
    chk(req, out_valid, 1'b0, "reset out_valid");
    chk(req, out_bit, 1'b0, "reset out_bit");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req, out_valid, 1'b0, "idle after reset out_valid");

    req = "R7";
    put(1, 0, 0); put(0, 0, 0); put(1, 0, 0); put(1, 0, 0);
    rand_bits(36, 0, 0);
    req = "R2";
    rand_bits(60, 0, 0);
    req = "R3";
    for (int i = 0; i < 120; i++)
      put((i % 2 == 0) ? bit'((i / 2) % 2) : bit'((i / 4) % 2), 0, 0);
    req = "R4";
    rand_bits(400, 0, 0);
    req = "R5";
    rand_bits(3000, 2, 0);
    req = "R6";
    rand_bits(800, 2, 30);
    flush(6);

    req = "R8";
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_clear();
    @(negedge clk);
    chk(req, out_valid, 1'b0, "mid reset out_valid");
    rst_n = 1'b1;
    put(1, 1, 0);
    put(1, -1, 0);
    rand_bits(150, 1, 10);
    flush(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule